// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Select

This block decides, for each of the two source operands of the instruction now in the execute stage of a five-stage pipeline, where the operand value should come from. There are three candidate sources. The register file gives the value read during decode. The stage register just after execute holds the newest result. The stage register before writeback holds the result one instruction older. The block is purely combinational. It compares the two source register numbers held in the decode/execute stage register with the destination numbers and write flags of the two later stages, and drives one 2-bit select per operand to an external operand multiplexer.

Select encoding: `00` means the register file, `10` means the execute/memory stage result, and `01` means the memory/writeback stage result. The code `11` is never produced. The two operands are resolved with the same rules, each on its own. When both later stages target the same register, the younger instruction (execute/memory) supplies the value. A stage that is not writing, or that writes register 0, never supplies a value.

Top module: `exe_bypass_ctl`

## Requirements
- R1: `sel_a_o` is `10` whenever `xm_wen_i` is 1, `xm_dst_i` is nonzero and `xm_dst_i` equals `ex_src_a_i`.
- R2: `sel_b_o` is `10` whenever `xm_wen_i` is 1, `xm_dst_i` is nonzero and `xm_dst_i` equals `ex_src_b_i`.
- R3: If an operand has no execute/memory match but `mw_wen_i` is 1, `mw_dst_i` is nonzero and `mw_dst_i` equals that operand's source number, its select is `01`.
- R4: When both later stages match the same operand, the select is `10` (the younger result wins).
- R5: A stage whose write flag is 0 never causes a select of `10` (execute/memory) or `01` (memory/writeback), whatever its destination number.
- R6: A destination number of 0 never causes forwarding, even with the write flag set and a source number of 0.
- R7: With no qualifying match, the select is `00` (register file).
- R8: The two selects are computed independently; equal source numbers always give equal selects, and a match on one operand does not change the other.
- R9: The select code `11` never appears on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_src_a_i | input | 5 | First source register number of the instruction in execute |
| ex_src_b_i | input | 5 | Second source register number of the instruction in execute |
| xm_dst_i | input | 5 | Destination register number in the execute/memory stage |
| xm_wen_i | input | 1 | Register-write flag of the execute/memory stage |
| mw_dst_i | input | 5 | Destination register number in the memory/writeback stage |
| mw_wen_i | input | 1 | Register-write flag of the memory/writeback stage |
| sel_a_o | output | 2 | Operand A source select (00 file, 10 exec/mem, 01 mem/wb) |
| sel_b_o | output | 2 | Operand B source select (00 file, 10 exec/mem, 01 mem/wb) |

## Verification
The checks assume the inputs are settled, known values at the moment they are evaluated; with a combinational block that means they read the ports after every input change, and the stimulus only changes inputs on the falling clock edge so nothing is judged mid-update. No assumption is made that the two stages hold distinct destinations or that write flags track anything, so the stimulus deliberately collides destinations, sets register 0 with the write flag on, and drops write flags while numbers still match. Random vectors draw register numbers from a small range so matches and double matches occur often rather than rarely.

// File: rtl/exe_bypass_pkg.sv
package exe_bypass_pkg;

  typedef enum logic [1:0] {
    SRC_REGFILE = 2'b00,
    SRC_MEMWB   = 2'b01,
    SRC_EXMEM   = 2'b10
  } opnd_src_e;

endpackage

// File: rtl/bypass_hit.sv
module bypass_hit #(
  parameter int REG_AW       = 5,
  parameter bit ZERO_IS_SINK = 1'b1
) (
  input  logic [REG_AW-1:0] src_i,
  input  logic [REG_AW-1:0] dst_i,
  input  logic              wen_i,
  output logic              hit_o
);

  logic dst_valid;
  logic num_equal;

  generate
    if (ZERO_IS_SINK) begin : g_zero_sink
      assign dst_valid = |dst_i;
    end else begin : g_no_sink
      assign dst_valid = 1'b1;
    end
  endgenerate

  assign num_equal = (src_i == dst_i);

  always_comb begin
    hit_o = wen_i & dst_valid & num_equal;
  end

endmodule

// File: rtl/bypass_pick.sv
module bypass_pick
  import exe_bypass_pkg::*;
(
  input  logic      hit_young_i,
  input  logic      hit_old_i,
  output opnd_src_e sel_o
);

  always_comb begin
    if (hit_young_i) begin
      sel_o = SRC_EXMEM;
    end else if (hit_old_i) begin
      sel_o = SRC_MEMWB;
    end else begin
      sel_o = SRC_REGFILE;
    end
  end

endmodule

// File: rtl/exe_bypass_ctl.sv
module exe_bypass_ctl
  import exe_bypass_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] ex_src_a_i,
  input  logic [REG_AW-1:0] ex_src_b_i,
  input  logic [REG_AW-1:0] xm_dst_i,
  input  logic              xm_wen_i,
  input  logic [REG_AW-1:0] mw_dst_i,
  input  logic              mw_wen_i,
  output logic [1:0]        sel_a_o,
  output logic [1:0]        sel_b_o
);

  localparam int NUM_OPND = 2;

  logic [REG_AW-1:0] src_num [NUM_OPND];
  opnd_src_e         sel     [NUM_OPND];

  assign src_num[0] = ex_src_a_i;
  assign src_num[1] = ex_src_b_i;

  generate
    for (genvar i = 0; i < NUM_OPND; i++) begin : g_opnd
      logic hit_xm;
      logic hit_mw;

      bypass_hit #(.REG_AW(REG_AW), .ZERO_IS_SINK(1'b1)) u_hit_xm (
        .src_i (src_num[i]),
        .dst_i (xm_dst_i),
        .wen_i (xm_wen_i),
        .hit_o (hit_xm)
      );

      bypass_hit #(.REG_AW(REG_AW), .ZERO_IS_SINK(1'b1)) u_hit_mw (
        .src_i (src_num[i]),
        .dst_i (mw_dst_i),
        .wen_i (mw_wen_i),
        .hit_o (hit_mw)
      );

      bypass_pick u_pick (
        .hit_young_i (hit_xm),
        .hit_old_i   (hit_mw),
        .sel_o       (sel[i])
      );
    end
  endgenerate

  assign sel_a_o = sel[0];
  assign sel_b_o = sel[1];

endmodule

// File: rtl/exe_bypass_chk.sv
module exe_bypass_chk #(
  parameter int REG_AW = 5
) (
  input logic [REG_AW-1:0] ex_src_a_i,
  input logic [REG_AW-1:0] ex_src_b_i,
  input logic [REG_AW-1:0] xm_dst_i,
  input logic              xm_wen_i,
  input logic [REG_AW-1:0] mw_dst_i,
  input logic              mw_wen_i,
  input logic [1:0]        sel_a_o,
  input logic [1:0]        sel_b_o
);

  always_comb begin
    AST_XM_WINS_A: assert (!(xm_wen_i && (xm_dst_i != '0) && (xm_dst_i == ex_src_a_i)) || (sel_a_o == 2'b10)) else $error("xm select A"); // R1
    AST_XM_WINS_B: assert (!(xm_wen_i && (xm_dst_i != '0) && (xm_dst_i == ex_src_b_i)) || (sel_b_o == 2'b10)) else $error("xm select B"); // R2
    AST_MW_ONLY_A: assert (!(!(xm_wen_i && (xm_dst_i == ex_src_a_i)) && mw_wen_i && (mw_dst_i != '0) && (mw_dst_i == ex_src_a_i)) || (sel_a_o == 2'b01)) else $error("mw select A"); // R3
    AST_NO_WRITERS: assert ((xm_wen_i || mw_wen_i) || ((sel_a_o == 2'b00) && (sel_b_o == 2'b00))) else $error("select without writer"); // R5
    AST_ZERO_SRC_A: assert ((ex_src_a_i != '0) || (sel_a_o == 2'b00)) else $error("zero register forwarded"); // R6
    AST_SAME_SRC: assert ((ex_src_a_i != ex_src_b_i) || (sel_a_o == sel_b_o)) else $error("selects differ"); // R8
    AST_NO_CODE3: assert ((sel_a_o != 2'b11) && (sel_b_o != 2'b11)) else $error("illegal code"); // R9
  end

endmodule

bind exe_bypass_ctl exe_bypass_chk #(.REG_AW(REG_AW)) u_chk (
  .ex_src_a_i (ex_src_a_i),
  .ex_src_b_i (ex_src_b_i),
  .xm_dst_i   (xm_dst_i),
  .xm_wen_i   (xm_wen_i),
  .mw_dst_i   (mw_dst_i),
  .mw_wen_i   (mw_wen_i),
  .sel_a_o    (sel_a_o),
  .sel_b_o    (sel_b_o)
);

// File: tb/exe_bypass_ctl_tb.sv
`timescale 1ns/1ps
module exe_bypass_ctl_tb;

  logic       clk;
  logic       rst_n;
  logic [4:0] src_a, src_b, xm_dst, mw_dst;
  logic       xm_wen, mw_wen;
  logic [1:0] sel_a, sel_b;

  int n_chk;
  int n_fail;

  exe_bypass_ctl u_dut (
    .ex_src_a_i (src_a),
    .ex_src_b_i (src_b),
    .xm_dst_i   (xm_dst),
    .xm_wen_i   (xm_wen),
    .mw_dst_i   (mw_dst),
    .mw_wen_i   (mw_wen),
    .sel_a_o    (sel_a),
    .sel_b_o    (sel_b)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Behavioural expectation: youngest writing stage with a real destination wins.
  function automatic logic [1:0] expect_sel(input int src, input int xd, input bit xw,
                                            input int md, input bit mwr);
    if (xw && xd != 0 && xd == src) return 2'b10;
    if (mwr && md != 0 && md == src) return 2'b01;
    return 2'b00;
  endfunction

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b (a=%0d b=%0d xm=%0d/%0b mw=%0d/%0b)",
               req, act, exp, src_a, src_b, xm_dst, xm_wen, mw_dst, mw_wen);
    end
  endtask

  task automatic apply(input int a, input int b, input int xd, input bit xw,
                       input int md, input bit mwr, input string req);
    @(negedge clk);
    src_a = 5'(a); src_b = 5'(b);
    xm_dst = 5'(xd); xm_wen = xw;
    mw_dst = 5'(md); mw_wen = mwr;
    @(posedge clk);
    #1;
    check({req, " opA"}, sel_a, expect_sel(a, xd, xw, md, mwr));
    check({req, " opB"}, sel_b, expect_sel(b, xd, xw, md, mwr));
    check("R9 no code 11", {sel_a == 2'b11, sel_b == 2'b11}, 2'b00);
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0;
    src_a = '0; src_b = '0; xm_dst = '0; mw_dst = '0; xm_wen = 1'b0; mw_wen = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R7 reset state A", sel_a, 2'b00);
    check("R7 reset state B", sel_b, 2'b00);
    rst_n = 1'b1;

    apply(3, 9, 3, 1, 0, 0, "R1 xm match A");
    apply(4, 12, 12, 1, 0, 0, "R2 xm match B");
    apply(7, 2, 0, 0, 7, 1, "R3 mw match A");
    apply(6, 15, 1, 1, 15, 1, "R3 mw match B");
    apply(8, 8, 8, 1, 8, 1, "R4 both match");
    apply(5, 10, 5, 1, 10, 1, "R4 R8 split stages");
    apply(11, 11, 11, 0, 0, 0, "R5 xm not writing");
    apply(11, 20, 20, 0, 11, 0, "R5 neither writing");
    apply(14, 14, 14, 0, 14, 1, "R5 xm off mw on");
    apply(0, 0, 0, 1, 0, 1, "R6 zero dest");
    apply(0, 9, 0, 1, 9, 1, "R6 zero dest A only");
    apply(1, 2, 3, 1, 4, 1, "R7 no match");
    apply(31, 31, 31, 1, 30, 1, "R8 same source");

    for (int i = 0; i < 400; i++) begin
      apply(int'($urandom_range(0, 5)), int'($urandom_range(0, 5)),
            int'($urandom_range(0, 5)), 1'($urandom_range(0, 1)),
            int'($urandom_range(0, 5)), 1'($urandom_range(0, 1)),
            "R1 R2 R3 R4 R5 R6 R7 R8 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule